// File: doc/BRIEF.md
# Execution Unit Error Status Controller

This block keeps the error-interrupt state for one execution unit of a security engine. Error events from the unit's datapath arrive as a vector. Each event passes through a programmable mask and is latched into a sticky status register. While any status bit is set, the block halts the unit and drives an error interrupt toward the controller. When the unit is assigned to a channel, the block also raises a channel error indication.

A small host register port reads and writes four words: the mask, the interrupt status, a read-only summary word and a reset-control word. A write to the status word is not a write-1-to-clear. The written value, limited by the mask, replaces the stored contents. After the block's synchronous reset is released, it runs a fixed internal reset sequence before it reports ready.

Top module: `eu_err_ctrl`

## Requirements
- R1: A status bit can only become set by an event or write when the matching mask bit is 0. A masked event leaves the status, `err_irq` and `halt` unchanged.
- R2: Whenever the status register is nonzero, `err_irq` and `halt` are both 1.
- R3: A host write to address 1 stores `wdata & ~mask` in the low 8 bits of the status register. This clears masked bits and bits written as 0.
- R4: A write to address 3 with bit 0 set clears the status register.
- R5: `chan_err_irq` is 1 only when `err_irq` is 1 and `chan_assigned` is 1.
- R6: The summary word at address 2 has halt at bit 5, the error-interrupt level at bit 2, the `done_irq` level at bit 1 and reset-done at bit 0. All other bits read 0.
- R7: After `rst_n` is released, `reset_done` stays 0 and `halt` stays 1 for 16 clock edges. Host writes during that window are ignored. `reset_done` is 1 after the 16th edge.
- R8: An unmasked event sets its status bit on the same clock edge. The bit stays set after the event goes away. A status write in the same cycle as an event keeps that event's bit set.
- R9: The mask register (address 0, low 8 bits) resets to all ones.
- R10: When the status register returns to zero, `halt` stays 1 for one more cycle and then falls to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_event | input | 8 | Error event vector from the datapath |
| done_irq | input | 1 | Done-interrupt level from the datapath |
| chan_assigned | input | 1 | Unit is owned by a channel |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 2 | Host word address |
| reg_wdata | input | 64 | Host write data |
| reg_rdata | output | 64 | Host read data, combinational |
| halt | output | 1 | Unit halted (reset sequence or error) |
| err_irq | output | 1 | Error interrupt to controller |
| chan_err_irq | output | 1 | Error indication to owning channel |
| reset_done | output | 1 | Internal reset sequence finished |

## Verification
The bench uses the default parameters: eight event lines, a 16-cycle reset sequence and a 64-bit register word. With these values, every reset-window edge can be counted one by one. The mask can also be split into masked and unmasked halves, so a single write or event pattern exercises both paths at once.

// File: rtl/eu_err_pkg.sv
// Shared constants for the execution-unit error status controller.
// Assumes a four-word host register map with word addresses 0..3.
package eu_err_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_MASK   = 2'd0;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd1;
    localparam logic [ADDR_W-1:0] A_SUMMARY = 2'd2;
    localparam logic [ADDR_W-1:0] A_RSTCTL = 2'd3;
    // Summary word bit positions (LSB = 0)
    localparam int SUM_RDONE = 0;
    localparam int SUM_DONE  = 1;
    localparam int SUM_ERR   = 2;
    localparam int SUM_HALT  = 5;
    // Reset-control word: bit that clears the status register
    localparam int RST_CLR_BIT = 0;
endpackage

// File: rtl/eu_rst_seq.sv
// Internal reset sequencer: counts RST_CYCLES edges after rst_n is released.
// Assumes rst_n is synchronous and active low. busy is high until the count ends.
module eu_rst_seq #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic busy
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(RST_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Advance the sequence counter until it reaches its end value
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (cnt_q != CNT_END) cnt_q <= cnt_q + 1'b1;
    end

    assign busy = (cnt_q != CNT_END);

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_END);
    assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy);
endmodule

// File: rtl/eu_err_status.sv
// Mask and sticky interrupt-status register with error-halt tracking.
// Assumes at most one of mask_wr, stat_wr and clr_wr is high per cycle.
// While hold is high, all state is held at reset values.
module eu_err_status #(
    parameter int NUM_ERR = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic [NUM_ERR-1:0] err_event,
    input  logic               mask_wr,
    input  logic               stat_wr,
    input  logic               clr_wr,
    input  logic [NUM_ERR-1:0] wdata,
    output logic [NUM_ERR-1:0] mask_q,
    output logic [NUM_ERR-1:0] status_q,
    output logic               halt_err
);
    logic [NUM_ERR-1:0] base_d, status_d;

    // Choose the retained status: host replace, clear, or keep
    always_comb begin
        if (stat_wr)     base_d = wdata & ~mask_q;
        else if (clr_wr) base_d = '0;
        else             base_d = status_q;
        status_d = base_d | (err_event & ~mask_q);
    end

    // Mask register, all errors masked at reset
    always_ff @(posedge clk) begin
        if (!rst_n || hold) mask_q <= '1;
        else if (mask_wr)   mask_q <= wdata;
    end

    // Sticky status register
    always_ff @(posedge clk) begin
        if (!rst_n || hold) status_q <= '0;
        else                status_q <= status_d;
    end

    // Halt rises with the status and falls one cycle after the status clears
    always_ff @(posedge clk) begin
        if (!rst_n || hold) halt_err <= 1'b0;
        else                halt_err <= (|status_d) | (halt_err & (|status_q));
    end

    assert_masked_no_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~$past(status_q) & $past(mask_q)) == '0));
    assert_halt_on_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|status_q) |-> halt_err);
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !hold) |=> (status_q == $past(err_event & ~mask_q)));
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_wr && !clr_wr && !hold) |=> ((status_q & $past(status_q)) == $past(status_q)));
    assert_halt_tail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && status_q == '0 && $past(status_q) != '0) |-> halt_err);
endmodule

// File: rtl/eu_err_regif.sv
// Host register decode and read mux for the error status controller.
// Assumes single-cycle writes. Writes are dropped while hold is high.
module eu_err_regif
    import eu_err_pkg::*;
#(
    parameter int NUM_ERR = 8,
    parameter int DATA_W  = 64
) (
    input  logic               hold,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic [NUM_ERR-1:0] mask_q,
    input  logic [NUM_ERR-1:0] status_q,
    input  logic               halt,
    input  logic               err_irq,
    input  logic               done_irq,
    input  logic               reset_done,
    output logic               mask_wr,
    output logic               stat_wr,
    output logic               clr_wr,
    output logic [NUM_ERR-1:0] wdata,
    output logic [DATA_W-1:0]  reg_rdata
);
    logic wr_ok;
    logic unused_wdata;

    assign wr_ok   = reg_wr && !hold;
    assign mask_wr = wr_ok && (reg_addr == A_MASK);
    assign stat_wr = wr_ok && (reg_addr == A_STATUS);
    assign clr_wr  = wr_ok && (reg_addr == A_RSTCTL) && reg_wdata[RST_CLR_BIT];
    assign wdata   = reg_wdata[NUM_ERR-1:0];
    assign unused_wdata = &{1'b0, reg_wdata[DATA_W-1:NUM_ERR]};

    // Select the addressed word for the host
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_MASK:   reg_rdata[NUM_ERR-1:0] = mask_q;
            A_STATUS: reg_rdata[NUM_ERR-1:0] = status_q;
            A_SUMMARY: begin
                reg_rdata[SUM_HALT]  = halt;
                reg_rdata[SUM_ERR]   = err_irq;
                reg_rdata[SUM_DONE]  = done_irq;
                reg_rdata[SUM_RDONE] = reset_done;
            end
            default:  reg_rdata = '0;
        endcase
    end

    assert_one_write_R3: assert final ($onehot0({mask_wr, stat_wr, clr_wr}));
endmodule

// File: rtl/eu_err_ctrl.sv
// Top of the execution-unit error status controller: sequencer, status
// register and host interface. Assumes err_event and done_irq are synchronous to clk.
module eu_err_ctrl
    import eu_err_pkg::*;
#(
    parameter int NUM_ERR    = 8,
    parameter int RST_CYCLES = 16,
    parameter int DATA_W     = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ERR-1:0] err_event,
    input  logic               done_irq,
    input  logic               chan_assigned,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               halt,
    output logic               err_irq,
    output logic               chan_err_irq,
    output logic               reset_done
);
    logic               busy;
    logic               mask_wr, stat_wr, clr_wr, halt_err;
    logic [NUM_ERR-1:0] wdata, mask_q, status_q;

    eu_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .busy(busy)
    );

    eu_err_status #(.NUM_ERR(NUM_ERR)) u_stat (
        .clk(clk), .rst_n(rst_n), .hold(busy), .err_event(err_event),
        .mask_wr(mask_wr), .stat_wr(stat_wr), .clr_wr(clr_wr), .wdata(wdata),
        .mask_q(mask_q), .status_q(status_q), .halt_err(halt_err)
    );

    eu_err_regif #(.NUM_ERR(NUM_ERR), .DATA_W(DATA_W)) u_regs (
        .hold(busy), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .mask_q(mask_q), .status_q(status_q), .halt(halt), .err_irq(err_irq),
        .done_irq(done_irq), .reset_done(reset_done), .mask_wr(mask_wr),
        .stat_wr(stat_wr), .clr_wr(clr_wr), .wdata(wdata), .reg_rdata(reg_rdata)
    );

    assign reset_done   = !busy;
    assign halt         = busy | halt_err;
    assign err_irq      = |status_q;
    assign chan_err_irq = err_irq & chan_assigned;

    assert_irq_halts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> halt);
    assert_chan_needs_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chan_err_irq |-> (err_irq && halt));
    assert_not_ready_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !reset_done |-> (halt && !err_irq));
endmodule

// File: tb/sim_eu_err_ctrl.sv
module sim_eu_err_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  err_event = '0;
    logic        done_irq = 1'b0;
    logic        chan_assigned = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        halt, err_irq, chan_err_irq, reset_done;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    eu_err_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .err_event(err_event), .done_irq(done_irq),
        .chan_assigned(chan_assigned), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .halt(halt),
        .err_irq(err_irq), .chan_err_irq(chan_err_irq), .reset_done(reset_done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // One write cycle, optionally with an event in the same cycle
    task automatic wr(input logic [1:0] a, input logic [63:0] d, input logic [7:0] ev);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; err_event = ev;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; err_event = '0;
    endtask

    task automatic pulse(input logic [7:0] ev);
        @(negedge clk);
        err_event = ev;
        @(negedge clk);
        err_event = '0;
    endtask

    task automatic t_reset_seq();
        logic [63:0] d;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 15; i++) begin
            reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 64'h0;
            err_event = 8'hFF;
            @(negedge clk);
        end
        reg_wr = 1'b0; err_event = '0;
        check("R7 reset_done low after 15 edges", reset_done, 0);
        check("R7 halt during sequence", halt, 1);
        rd(2'd2, d);
        check("R6 summary during sequence", d, 64'h20);
        @(negedge clk);
        check("R7 reset_done after 16 edges", reset_done, 1);
        check("R7 halt released", halt, 0);
        rd(2'd0, d);
        check("R9 R7 mask all ones, writes ignored", d, 64'hFF);
        rd(2'd1, d);
        check("R7 status empty after sequence", d, 0);
    endtask

    task automatic t_mask_gate();
        logic [63:0] d;
        pulse(8'h01);
        rd(2'd1, d);
        check("R1 masked event ignored", d, 0);
        check("R1 masked event no irq", err_irq, 0);
        check("R1 masked event no halt", halt, 0);
        wr(2'd0, 64'hF0, 8'h00);
        pulse(8'h11);
        rd(2'd1, d);
        check("R1 R8 only unmasked bit captured", d, 64'h01);
        check("R2 err_irq on error", err_irq, 1);
        check("R2 halt on error", halt, 1);
        @(negedge clk);
        rd(2'd1, d);
        check("R8 status sticky", d, 64'h01);
    endtask

    task automatic t_host_write();
        logic [63:0] d;
        wr(2'd1, 64'hFFFF_0000_0000_003C, 8'h00);
        rd(2'd1, d);
        check("R3 write stores unmasked ones only", d, 64'h0C);
        wr(2'd1, 64'h0, 8'h02);
        rd(2'd1, d);
        check("R8 same-cycle event survives write", d, 64'h02);
    endtask

    task automatic t_summary();
        logic [63:0] d;
        done_irq = 1'b1;
        rd(2'd2, d);
        check("R6 summary with error and done", d, 64'h27);
        done_irq = 1'b0;
    endtask

    task automatic t_channel();
        chan_assigned = 1'b1;
        #1;
        check("R5 channel error when assigned", chan_err_irq, 1);
        chan_assigned = 1'b0;
        #1;
        check("R5 no channel error when unassigned", chan_err_irq, 0);
    endtask

    task automatic t_clear();
        logic [63:0] d;
        wr(2'd3, 64'h0, 8'h00);
        rd(2'd1, d);
        check("R4 reset-control without bit 0 keeps status", d, 64'h02);
        wr(2'd3, 64'h1, 8'h00);
        rd(2'd1, d);
        check("R4 clear bit empties status", d, 0);
        check("R10 halt held one cycle", halt, 1);
        check("R2 err_irq drops with status", err_irq, 0);
        @(negedge clk);
        check("R10 halt released next cycle", halt, 0);
        rd(2'd2, d);
        check("R6 summary idle", d, 64'h01);
    endtask

    initial begin
        t_reset_seq();
        t_mask_gate();
        t_host_write();
        t_summary();
        t_channel();
        t_clear();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule